// File: doc/BRIEF.md
# Performance Counter Gating and Interrupt Controller

This block holds the control word for a pair of hardware event counters. Each cycle it decides whether the counters may advance. The decision draws on a global stop bit, the current privilege level (user or supervisor) and a per-process mark bit. Each counter adds one on its own event pulse when counting is allowed. Software can load either counter at any time, whatever the gating.

The block also raises a monitor interrupt in two cases. The first is when a counter whose interrupt control bit is set has its most significant bit at one. The second is when a selected time-base bit reports a transition. In both cases the global interrupt enable must be set. Raising the interrupt clears that enable in hardware, so software must set it again after servicing.

An optional freeze mode stops both counters at the moment an interrupt is raised. This keeps the counts for software to inspect. A later control write releases the freeze.

Top module: `pmon_ctrl`

## Requirements
- R1: After reset the control word, both counters and `irq` are zero. Reading `cfg_rdata` never changes the control word.
- R2: Only these control bits are stored: [31] stop-all, [30] stop-in-supervisor, [29] stop-in-user, [28] stop-when-mark-high, [27] stop-when-mark-low, [26] interrupt enable, [25] freeze-on-interrupt, [24:23] time-base select, [22] time-base interrupt enable, [15] counter 0 interrupt control, [14] counter 1 interrupt control. Every other bit reads as zero.
- R3: A counter adds exactly one at the clock edge that ends a cycle in which its event pulse is high and counting is allowed. A software load (`ctr_wr_en[i]`) writes `ctr_wdata`, takes priority over the increment and works even when counting is blocked.
- R4: While bit [31] is set, neither counter changes in hardware.
- R5: Bit [30] blocks counting while `priv_user` is 0. Bit [29] blocks counting while `priv_user` is 1.
- R6: Bit [28] blocks counting while `proc_mark` is 1. Bit [27] blocks counting while `proc_mark` is 0.
- R7: A counter condition exists in a cycle when [26] is 1, the counter's interrupt control bit is 1 and the counter's bit [31] is 1.
- R8: A time-base condition exists in a cycle when [26] and [22] are 1 and `tb_pulse[sel]` is 1, where sel is the value of field [24:23]. Pulses on the other lanes are ignored.
- R9: `irq` is high for one cycle, in the cycle after a condition. Bit [26] reads 0 from that same cycle onward, unless software wrote the control word in the condition cycle.
- R10: A counter condition and a time-base condition in the same cycle give a single `irq` pulse.
- R11: With [25] set, neither counter increments from the condition cycle onward. With [25] clear, an interrupt has no effect on counting.
- R12: A freeze stays in place until a control write that clears [25] or sets [26]. A write that does neither keeps the counters frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word |
| ctr_wr_en | input | 2 | Per-counter software load strobes |
| ctr_wdata | input | 32 | Counter load value |
| priv_user | input | 1 | 1 = user level, 0 = supervisor level |
| proc_mark | input | 1 | Process mark status |
| evt | input | 2 | Per-counter event pulses |
| tb_pulse | input | 4 | Time-base transition pulses, one lane per selectable bit |
| ctr0_val | output | 32 | Counter 0 value |
| ctr1_val | output | 32 | Counter 1 value |
| irq | output | 1 | Monitor interrupt pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a counter crossing into its sign bit and a pulse on the selected time-base lane. The bench loads counter 1 with its sign bit set while interrupts are disabled, then enables interrupts and drives the selected lane in the first enabled cycle. It counts the `irq` cycles in a window that follows and expects exactly one. The second pair is freeze and increment: with events held high, a counter that crosses its sign bit must hold its value from the condition cycle onward. Its neighbour must stop on the same edge.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int CFG_W    = 32;
  localparam int NCTR     = 2;
  localparam int TB_N     = 4;
  localparam int TB_SEL_W = $clog2(TB_N);

  localparam int B_STOP   = 31;
  localparam int B_SUPOFF = 30;
  localparam int B_USROFF = 29;
  localparam int B_MHIOFF = 28;
  localparam int B_MLOOFF = 27;
  localparam int B_IEN    = 26;
  localparam int B_FRZ    = 25;
  localparam int B_TBSEL  = 23;
  localparam int B_TBIEN  = 22;
  localparam int B_IC0    = 15;

  localparam logic [CFG_W-1:0] CFG_MASK = 32'hFFC0_C000;

  function automatic logic count_blocked(logic [CFG_W-1:0] c, logic user, logic mark);
    return c[B_STOP]
         | (c[B_SUPOFF] & ~user) | (c[B_USROFF] & user)
         | (c[B_MHIOFF] & mark)  | (c[B_MLOOFF] & ~mark);
  endfunction

  function automatic logic [TB_SEL_W-1:0] tb_select(logic [CFG_W-1:0] c);
    return c[B_TBSEL +: TB_SEL_W];
  endfunction

  function automatic logic ctr_condition(logic [CFG_W-1:0] c, logic [NCTR-1:0] msb);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NCTR; i++) hit = hit | (c[B_IC0 - i] & msb[i]);
    return c[B_IEN] & hit;
  endfunction

  function automatic logic tb_condition(logic [CFG_W-1:0] c, logic [TB_N-1:0] tbp);
    return c[B_IEN] & c[B_TBIEN] & tbp[tb_select(c)];
  endfunction
endpackage

// File: rtl/pmon_cfg_reg.sv
module pmon_cfg_reg
  import pmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic             sig_now,
  output logic [CFG_W-1:0] cfg_q,
  output logic             frozen_q
);
  logic release_wr;
  logic freeze_set;

  assign release_wr = wr_en & (~wdata[B_FRZ] | wdata[B_IEN]);
  assign freeze_set = sig_now & cfg_q[B_FRZ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      frozen_q <= 1'b0;
    end else begin
      if (wr_en)
        cfg_q <= wdata & CFG_MASK;
      else if (sig_now)
        cfg_q[B_IEN] <= 1'b0;
      if (release_wr)
        frozen_q <= 1'b0;
      else if (freeze_set)
        frozen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pmon_irq.sv
module pmon_irq
  import pmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic [NCTR-1:0]  msb,
  input  logic [TB_N-1:0]  tb_pulse,
  output logic             cond,
  output logic             irq_q
);
  logic ctr_hit;
  logic tb_hit;

  assign ctr_hit = ctr_condition(cfg, msb);
  assign tb_hit  = tb_condition(cfg, tb_pulse);
  assign cond    = ctr_hit | tb_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= cond;
  end
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [NCTR-1:0]  ctr_wr_en,
  input  logic [CTR_W-1:0] ctr_wdata,
  input  logic             priv_user,
  input  logic             proc_mark,
  input  logic [NCTR-1:0]  evt,
  input  logic [TB_N-1:0]  tb_pulse,
  output logic [CTR_W-1:0] ctr0_val,
  output logic [CTR_W-1:0] ctr1_val,
  output logic             irq
);
  logic [CFG_W-1:0] cfg;
  logic             frozen;
  logic             irq_cond;
  logic             count_ok;
  logic [NCTR-1:0]  msb;
  logic [CTR_W-1:0] ctr_q [NCTR];

  pmon_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata),
    .sig_now(irq_cond), .cfg_q(cfg), .frozen_q(frozen)
  );

  pmon_irq u_irq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .msb(msb),
    .tb_pulse(tb_pulse), .cond(irq_cond), .irq_q(irq)
  );

  assign count_ok = ~count_blocked(cfg, priv_user, proc_mark)
                  & ~frozen & ~(irq_cond & cfg[B_FRZ]);

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    pmon_counter #(.W(CTR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .ld(ctr_wr_en[i]), .ld_val(ctr_wdata),
      .inc(evt[i] & count_ok), .q(ctr_q[i])
    );
    assign msb[i] = ctr_q[i][CTR_W-1];
  end

  assign cfg_rdata = cfg;
  assign ctr0_val  = ctr_q[0];
  assign ctr1_val  = ctr_q[1];
endmodule

// File: rtl/pmon_ctrl_chk.sv
module pmon_ctrl_chk #(
  parameter int CTR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [31:0]      cfg_rdata,
  input logic [1:0]       ctr_wr_en,
  input logic [CTR_W-1:0] ctr0_val,
  input logic [CTR_W-1:0] ctr1_val,
  input logic             irq,
  input logic             frozen
);
  // R4
  stop_hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31] && !ctr_wr_en[0] |=> $stable(ctr0_val));

  // R4
  stop_hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31] && !ctr_wr_en[1] |=> $stable(ctr1_val));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctr_wr_en[0] |=> (ctr0_val == $past(ctr0_val)) || (ctr0_val == $past(ctr0_val) + 1'b1));

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !$past(cfg_wr_en) |=> !irq);

  // R9
  ien_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !$past(cfg_wr_en) |-> !cfg_rdata[26]);

  // R7
  irq_needs_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cfg_rdata[26]));

  // R11
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !cfg_wr_en && !ctr_wr_en[1] |=> $stable(ctr1_val));

  // R12
  frozen_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> cfg_rdata[25]);
endmodule

bind pmon_ctrl pmon_ctrl_chk #(.CTR_W(CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rdata(cfg_rdata),
  .ctr_wr_en(ctr_wr_en), .ctr0_val(ctr0_val), .ctr1_val(ctr1_val),
  .irq(irq), .frozen(frozen)
);

// File: tb/tb_pmon_ctrl.sv
`timescale 1ns/1ps
module tb_pmon_ctrl;
  localparam logic [31:0] STOP = 32'h8000_0000, SUPO = 32'h4000_0000, USRO = 32'h2000_0000;
  localparam logic [31:0] MHIO = 32'h1000_0000, MLOO = 32'h0800_0000, IEN = 32'h0400_0000;
  localparam logic [31:0] FRZ = 32'h0200_0000, TBIE = 32'h0040_0000;
  localparam logic [31:0] IC0 = 32'h0000_8000, IC1 = 32'h0000_4000;

  logic        clk = 0, rst_n = 0, cfg_wr_en = 0, priv_user = 0, proc_mark = 0;
  logic [31:0] cfg_wdata = 0, ctr_wdata = 0;
  logic [1:0]  ctr_wr_en = 0, evt = 0;
  logic [3:0]  tb_pulse = 0;
  logic [31:0] cfg_rdata, ctr0_val, ctr1_val;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pmon_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ctr_wr_en(ctr_wr_en), .ctr_wdata(ctr_wdata),
    .priv_user(priv_user), .proc_mark(proc_mark), .evt(evt), .tb_pulse(tb_pulse),
    .ctr0_val(ctr0_val), .ctr1_val(ctr1_val), .irq(irq)
  );

  function automatic logic [31:0] tbsel(int n);
    return 32'(n) << 23;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr_cfg(logic [31:0] v);
    cfg_wr_en = 1; cfg_wdata = v; tick(); cfg_wr_en = 0;
  endtask

  task automatic ld_ctr(int i, logic [31:0] v);
    ctr_wr_en = 2'b01 << i; ctr_wdata = v; tick(); ctr_wr_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 cfg", cfg_rdata, 0); chk("R1 ctr0", ctr0_val, 0);
    chk("R1 ctr1", ctr1_val, 0); chk("R1 irq", {31'b0, irq}, 0);
    wr_cfg(SUPO | IC1); tick(3);
    chk("R1 read stable", cfg_rdata, SUPO | IC1);
    wr_cfg(0);
  endtask

  task automatic t_layout;
    wr_cfg(32'hFFFF_FFFF);
    chk("R2 mask", cfg_rdata, 32'hFFC0_C000);
    wr_cfg(0);
  endtask

  task automatic t_count;
    evt = 2'b11; tick(5); evt = 0;
    chk("R3 ctr0 five", ctr0_val, 5); chk("R3 ctr1 five", ctr1_val, 5);
    evt = 2'b01; ctr_wr_en = 2'b01; ctr_wdata = 100; tick();
    ctr_wr_en = 0; evt = 0;
    chk("R3 load wins", ctr0_val, 100);
  endtask

  task automatic t_stop;
    logic [31:0] a;
    a = ctr0_val;
    wr_cfg(STOP); evt = 2'b11; tick(3);
    chk("R4 ctr0 held", ctr0_val, a);
    ld_ctr(1, 32'h1234);
    tick(2); evt = 0;
    chk("R3 load while stopped", ctr1_val, 32'h1234);
    wr_cfg(0);
  endtask

  task automatic t_priv;
    logic [31:0] a;
    wr_cfg(SUPO); priv_user = 0; a = ctr0_val;
    evt = 2'b01; tick(3); chk("R5 supervisor blocked", ctr0_val, a);
    priv_user = 1; tick(3); chk("R5 user counts", ctr0_val, a + 3);
    evt = 0; wr_cfg(USRO); a = ctr0_val; evt = 2'b01;
    tick(2); chk("R5 user blocked", ctr0_val, a);
    priv_user = 0; tick(2); chk("R5 supervisor counts", ctr0_val, a + 2);
    evt = 0; wr_cfg(0);
  endtask

  task automatic t_mark;
    logic [31:0] a;
    wr_cfg(MHIO); proc_mark = 1; a = ctr1_val;
    evt = 2'b10; tick(3); chk("R6 mark high blocked", ctr1_val, a);
    proc_mark = 0; tick(2); chk("R6 mark low counts", ctr1_val, a + 2);
    evt = 0; wr_cfg(MLOO); a = ctr1_val; evt = 2'b10;
    tick(2); chk("R6 mark low blocked", ctr1_val, a);
    proc_mark = 1; tick(4); chk("R6 mark high counts", ctr1_val, a + 4);
    evt = 0; proc_mark = 0; wr_cfg(0);
  endtask

  task automatic t_ctr_irq;
    int hits;
    wr_cfg(IEN); ld_ctr(1, 32'h8000_0000);
    hits = 0; repeat (4) begin hits += int'(irq); tick(); end
    chk("R7 no control bit no irq", 32'(hits), 0);
    ld_ctr(1, 0); ld_ctr(0, 32'h7FFF_FFFF);
    wr_cfg(IEN | IC0);
    evt = 2'b01; tick(); evt = 0;
    chk("R7 sign reached", ctr0_val, 32'h8000_0000);
    chk("R9 no irq yet", {31'b0, irq}, 0);
    tick();
    chk("R7 irq raised", {31'b0, irq}, 1);
    chk("R9 enable cleared", cfg_rdata, IC0);
    tick();
    chk("R9 one cycle", {31'b0, irq}, 0);
    wr_cfg(0); ld_ctr(0, 0);
  endtask

  task automatic t_tb_irq;
    int hits;
    wr_cfg(IEN | tbsel(1));
    tb_pulse = 4'b0010; tick(); tb_pulse = 0;
    chk("R8 lane enable off", {31'b0, irq}, 0);
    wr_cfg(IEN | TBIE | tbsel(1));
    tb_pulse = 4'b0001; tick(); tb_pulse = 0;
    hits = 0; repeat (3) begin hits += int'(irq); tick(); end
    chk("R8 other lane ignored", 32'(hits), 0);
    tb_pulse = 4'b0010; tick(); tb_pulse = 0;
    chk("R8 selected lane irq", {31'b0, irq}, 1);
    chk("R9 enable cleared tb", cfg_rdata, TBIE | tbsel(1));
    tick();
    chk("R9 tb one cycle", {31'b0, irq}, 0);
    wr_cfg(0);
  endtask

  task automatic t_coinc;
    int hits;
    wr_cfg(IC1 | TBIE | tbsel(2)); ld_ctr(1, 32'h8000_0000);
    wr_cfg(IEN | IC1 | TBIE | tbsel(2));
    tb_pulse = 4'b0100;
    hits = 0;
    repeat (6) begin tick(); tb_pulse = 0; hits += int'(irq); end
    chk("R10 single pulse", 32'(hits), 1);
    wr_cfg(0); ld_ctr(1, 0);
  endtask

  task automatic t_freeze;
    logic [31:0] b;
    ld_ctr(0, 32'h7FFF_FFFF); ld_ctr(1, 10);
    wr_cfg(IEN | FRZ | IC0);
    evt = 2'b11; tick();
    chk("R11 reached sign", ctr0_val, 32'h8000_0000);
    chk("R11 neighbour before", ctr1_val, 11);
    tick();
    chk("R11 irq", {31'b0, irq}, 1);
    chk("R11 ctr0 frozen at cond", ctr0_val, 32'h8000_0000);
    chk("R11 ctr1 frozen at cond", ctr1_val, 11);
    tick(3);
    chk("R11 ctr1 still frozen", ctr1_val, 11);
    ld_ctr(1, 5);
    chk("R3 load while frozen", ctr1_val, 5);
    wr_cfg(FRZ); tick(2);
    chk("R12 plain write keeps freeze", ctr1_val, 5);
    wr_cfg(IEN | FRZ);
    b = ctr1_val; tick(2);
    chk("R12 released", ctr1_val, b + 2);
    evt = 0; wr_cfg(0); ld_ctr(0, 0); ld_ctr(1, 0);
  endtask

  task automatic t_nofreeze;
    ld_ctr(0, 32'h7FFF_FFFF);
    wr_cfg(IEN | IC0);
    evt = 2'b01; tick(); tick();
    chk("R11 irq without freeze", {31'b0, irq}, 1);
    chk("R11 counts through irq", ctr0_val, 32'h8000_0001);
    tick(); evt = 0;
    chk("R11 keeps counting", ctr0_val, 32'h8000_0002);
    wr_cfg(0); ld_ctr(0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset(); t_layout(); t_count(); t_stop(); t_priv(); t_mark();
    t_ctr_irq(); t_tb_irq(); t_coinc(); t_freeze(); t_nofreeze();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule